// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

The block is a field-configurable two-level logic array. An input word of 16 bits feeds 48 product terms. Each product term may use, for every input, its true literal, its complement literal, or neither. The 8 outputs are each formed as an OR of any subset of the product terms, followed by a per-output polarity stage that either inverts or passes the sum. A chip-select input, active LOW, gates the outputs.

Configuration sits in registers, one bit per cell. A one-clock write port with a program-enable qualifier sets or clears single cells. Synchronous reset returns every cell to the unprogrammed state. The outputs are registered, so they follow the inputs one clock later. A parameter picks the disable behaviour. The three-state variant drops the per-output enables when deselected. The open-collector variant keeps the pins reading HIGH.

Top module: `fpla_core`

## Requirements
- R1: While reset is high, `out_data` is all ones and `out_en` is all zeros. After reset every cell is unprogrammed, so each selected output reads 1.
- R2: A programmed true cell (plane code 0, `prog_term` = term, `prog_idx` = input) makes the term require that input to be 1.
- R3: A programmed complement cell (plane code 1) makes the term require that input to be 0.
- R4: A term with both the true and complement cells set for any one input always evaluates to 0.
- R5: A term with no input cell programmed evaluates to 1.
- R6: A sum cell (plane code 2, `prog_term` = term, `prog_idx` = output) adds that term to that output's OR. Terms without a sum cell have no effect on the output.
- R7: An output whose polarity cell (plane code 3, `prog_idx` = output, `prog_term` ignored) is clear presents the inverted sum. With the cell set, it presents the sum itself.
- R8: While `cs_n` is 1, `out_data` is all ones. `out_en` is all zeros when THREE_STATE is 1 and all ones when it is 0. While `cs_n` is 0, `out_en` is all ones.
- R9: With `prog_en` low, no cell changes.
- R10: A write whose `prog_term` is 48 or above changes no cell.
- R11: `out_data` reflects the `a_in` and `cs_n` sampled at the previous rising clock edge and holds between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| a_in | input | 16 | Input word |
| prog_en | input | 1 | Configuration write enable |
| prog_plane | input | 2 | Cell plane: 0 true, 1 complement, 2 sum, 3 polarity |
| prog_term | input | 6 | Product term index |
| prog_idx | input | 4 | Input index (planes 0, 1) or output index (planes 2, 3) |
| prog_val | input | 1 | Value written to the cell |
| out_data | output | 8 | Registered output values |
| out_en | output | 8 | Registered per-output drive enables |

## Verification
The case that is hardest to reach from the ports is a single output whose value depends on a term that is asserted while other terms feeding the same OR are not. Reaching it needs a specific configuration plus an input word that satisfies exactly that term. Directed setups build a short equation set where the satisfying vectors are known. A randomly configured array with sparse literals follows it, so that individual terms fire often enough under random input words. The both-literal case is forced directly on one term, and it also appears in the random configuration.

// File: rtl/fpla_pkg.sv
package fpla_pkg;
  typedef enum logic [1:0] {
    PL_TRUE = 2'd0,
    PL_COMP = 2'd1,
    PL_SUM  = 2'd2,
    PL_POL  = 2'd3
  } plane_e;
endpackage

// File: rtl/fpla_and_plane.sv
module fpla_and_plane #(
  parameter int N_IN  = 16,
  parameter int N_PT  = 48,
  parameter int PT_W  = 6,
  parameter int IDX_W = 4,
  localparam int IN_W = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_true,
  input  logic             we_comp,
  input  logic [PT_W-1:0]  wr_term,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [N_IN-1:0]  a_in,
  output logic [N_PT-1:0]  pterm
);
  logic [N_PT-1:0][N_IN-1:0] tcell;
  logic [N_PT-1:0][N_IN-1:0] ccell;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcell <= '0;
      ccell <= '0;
    end else begin
      if (we_true) tcell[wr_term][wr_idx[IN_W-1:0]] <= wr_val;
      if (we_comp) ccell[wr_term][wr_idx[IN_W-1:0]] <= wr_val;
    end
  end

  for (genvar m = 0; m < N_PT; m++) begin : g_term
    // a literal kills the term when the input disagrees with it
    assign pterm[m] = ~|((tcell[m] & ~a_in) | (ccell[m] & a_in));

    // R4: both literals of one input force the term low
    a_r4_both_literals_zero: assert property (@(posedge clk) disable iff (rst)
      (|(tcell[m] & ccell[m])) |-> !pterm[m]);
    // R5: a term with no literal is always true
    a_r5_empty_term_one: assert property (@(posedge clk) disable iff (rst)
      ((tcell[m] | ccell[m]) == '0) |-> pterm[m]);
  end

  // R9: cells hold when no write is issued
  a_r9_and_cells_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(we_true) && !$past(we_comp)) |-> ($stable(tcell) && $stable(ccell)));
endmodule

// File: rtl/fpla_or_plane.sv
module fpla_or_plane #(
  parameter int N_PT  = 48,
  parameter int N_OUT = 8,
  parameter int PT_W  = 6,
  parameter int OUT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_sum,
  input  logic             we_pol,
  input  logic [PT_W-1:0]  wr_term,
  input  logic [OUT_W-1:0] wr_out,
  input  logic             wr_val,
  input  logic [N_PT-1:0]  pterm,
  output logic [N_OUT-1:0] level
);
  logic [N_OUT-1:0][N_PT-1:0] scell;
  logic [N_OUT-1:0]           pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      scell <= '0;
      pol   <= '0;
    end else begin
      if (we_sum) scell[wr_out][wr_term] <= wr_val;
      if (we_pol) pol[wr_out] <= wr_val;
    end
  end

  for (genvar r = 0; r < N_OUT; r++) begin : g_sum
    logic s;
    assign s        = |(scell[r] & pterm);
    assign level[r] = pol[r] ? s : ~s;

    // R6/R7: an output with no sum cell and default polarity reads high
    a_r7_unused_output_high: assert property (@(posedge clk) disable iff (rst)
      (scell[r] == '0 && !pol[r]) |-> level[r]);
  end

  // R9: sum and polarity cells hold when no write is issued
  a_r9_or_cells_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(we_sum) && !$past(we_pol)) |-> ($stable(scell) && $stable(pol)));
endmodule

// File: rtl/fpla_out_stage.sv
module fpla_out_stage #(
  parameter int N_OUT       = 8,
  parameter bit THREE_STATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic [N_OUT-1:0] level,
  output logic [N_OUT-1:0] out_data,
  output logic [N_OUT-1:0] out_en
);
  localparam logic [N_OUT-1:0] OFF_EN = THREE_STATE ? '0 : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '1;
      out_en   <= '0;
    end else if (cs_n) begin
      out_data <= '1;
      out_en   <= OFF_EN;
    end else begin
      out_data <= level;
      out_en   <= '1;
    end
  end

  a_r8_deselect_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cs_n)) |-> (out_data == '1));
  a_r8_deselect_enable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cs_n)) |-> (out_en == OFF_EN));
  a_r8_select_enable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cs_n)) |-> (out_en == '1));
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cs_n)) |-> (out_data == $past(level)));
endmodule

// File: rtl/fpla_core.sv
module fpla_core #(
  parameter int N_IN        = 16,
  parameter int N_PT        = 48,
  parameter int N_OUT       = 8,
  parameter bit THREE_STATE = 1'b1,
  localparam int PT_W  = $clog2(N_PT),
  localparam int IN_W  = $clog2(N_IN),
  localparam int OUT_W = $clog2(N_OUT),
  localparam int IDX_W = (IN_W > OUT_W) ? IN_W : OUT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic [N_IN-1:0]  a_in,
  input  logic             prog_en,
  input  logic [1:0]       prog_plane,
  input  logic [PT_W-1:0]  prog_term,
  input  logic [IDX_W-1:0] prog_idx,
  input  logic             prog_val,
  output logic [N_OUT-1:0] out_data,
  output logic [N_OUT-1:0] out_en
);
  import fpla_pkg::*;

  plane_e          plane;
  logic            term_ok, in_ok, out_ok;
  logic            we_true, we_comp, we_sum, we_pol;
  logic [N_PT-1:0]  pterm;
  logic [N_OUT-1:0] level;

  assign plane   = plane_e'(prog_plane);
  assign term_ok = int'(prog_term) < N_PT;
  assign in_ok   = int'(prog_idx) < N_IN;
  assign out_ok  = int'(prog_idx) < N_OUT;
  assign we_true = prog_en && term_ok && in_ok && plane == PL_TRUE;
  assign we_comp = prog_en && term_ok && in_ok && plane == PL_COMP;
  assign we_sum  = prog_en && term_ok && out_ok && plane == PL_SUM;
  assign we_pol  = prog_en && out_ok && plane == PL_POL;

  fpla_and_plane #(.N_IN(N_IN), .N_PT(N_PT), .PT_W(PT_W), .IDX_W(IDX_W)) u_and (
    .clk(clk), .rst(rst), .we_true(we_true), .we_comp(we_comp),
    .wr_term(prog_term), .wr_idx(prog_idx), .wr_val(prog_val),
    .a_in(a_in), .pterm(pterm)
  );

  fpla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT), .PT_W(PT_W), .OUT_W(OUT_W)) u_or (
    .clk(clk), .rst(rst), .we_sum(we_sum), .we_pol(we_pol),
    .wr_term(prog_term), .wr_out(prog_idx[OUT_W-1:0]), .wr_val(prog_val),
    .pterm(pterm), .level(level)
  );

  fpla_out_stage #(.N_OUT(N_OUT), .THREE_STATE(THREE_STATE)) u_out (
    .clk(clk), .rst(rst), .cs_n(cs_n), .level(level),
    .out_data(out_data), .out_en(out_en)
  );

  // R10: an out-of-range term index never produces a plane write
  a_r10_term_range: assert property (@(posedge clk) disable iff (rst)
    (int'(prog_term) >= N_PT) |-> !(we_true || we_comp || we_sum));
endmodule

// File: tb/test_fpla_core.sv
`timescale 1ns/1ps
module test_fpla_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b0;
  logic [15:0] a_in = '0;
  logic        prog_en = 1'b0;
  logic [1:0]  prog_plane = '0;
  logic [5:0]  prog_term = '0;
  logic [3:0]  prog_idx = '0;
  logic        prog_val = 1'b0;
  logic [7:0]  data_ts, en_ts, data_oc, en_oc;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [15:0] mt [48];
  logic [15:0] mc [48];
  logic [47:0] ms [8];
  logic [7:0]  mp;

  always #10 clk = ~clk;

  fpla_core #(.THREE_STATE(1'b1)) i_fpla_core (
    .clk(clk), .rst(rst), .cs_n(cs_n), .a_in(a_in), .prog_en(prog_en),
    .prog_plane(prog_plane), .prog_term(prog_term), .prog_idx(prog_idx),
    .prog_val(prog_val), .out_data(data_ts), .out_en(en_ts)
  );

  fpla_core #(.THREE_STATE(1'b0)) i_fpla_core_oc (
    .clk(clk), .rst(rst), .cs_n(cs_n), .a_in(a_in), .prog_en(prog_en),
    .prog_plane(prog_plane), .prog_term(prog_term), .prog_idx(prog_idx),
    .prog_val(prog_val), .out_data(data_oc), .out_en(en_oc)
  );

  function automatic logic [7:0] f_level(input logic [15:0] a);
    logic [47:0] p;
    logic [7:0]  lv;
    for (int m = 0; m < 48; m++) p[m] = (((mt[m] & ~a) | (mc[m] & a)) == 16'h0);
    for (int r = 0; r < 8; r++) lv[r] = mp[r] ? (|(ms[r] & p)) : !(|(ms[r] & p));
    return lv;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic prog(input logic en, input logic [1:0] pl, input int term, input int idx, input logic v);
    @(negedge clk);
    prog_en = en; prog_plane = pl; prog_term = 6'(term); prog_idx = 4'(idx); prog_val = v;
    @(negedge clk);
    prog_en = 1'b0;
    if (en) begin
      case (pl)
        2'd0: if (term < 48) mt[term][idx] = v;
        2'd1: if (term < 48) mc[term][idx] = v;
        2'd2: if (term < 48) ms[idx][term] = v;
        default: mp[idx] = v;
      endcase
    end
  endtask

  task automatic apply(input string tag, input logic [15:0] a, input logic cs);
    logic [7:0] ed;
    @(negedge clk);
    a_in = a; cs_n = cs;
    @(posedge clk);
    @(negedge clk);
    ed = cs ? 8'hFF : f_level(a);
    chk(tag, {data_ts, en_ts}, {ed, cs ? 8'h00 : 8'hFF});
    chk(tag, {data_oc, en_oc}, {ed, 8'hFF});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int m = 0; m < 48; m++) begin mt[m] = '0; mc[m] = '0; end
    for (int r = 0; r < 8; r++) ms[r] = '0;
    mp = '0;

    // R1: reset values
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", {data_ts, en_ts}, 16'hFF00);
    chk("R1 reset", {data_oc, en_oc}, 16'hFF00);
    rst = 1'b0;
    apply("R1 unprogrammed", 16'hA5C3, 1'b0);

    // R2 R3: term 0 = A0 & ~A1, feeds out0 (non-inverting) and out1 (inverting)
    prog(1'b1, 2'd0, 0, 0, 1'b1);
    prog(1'b1, 2'd1, 0, 1, 1'b1);
    prog(1'b1, 2'd2, 0, 0, 1'b1);
    prog(1'b1, 2'd2, 0, 1, 1'b1);
    prog(1'b1, 2'd3, 0, 0, 1'b1);
    apply("R2 R3 R7 term true", 16'h0001, 1'b0);
    chk("R2 out0 high", {8'h0, data_ts}, {8'h0, 8'hFD});
    apply("R3 complement blocks", 16'h0003, 1'b0);
    apply("R2 true blocks", 16'h0000, 1'b0);

    // R11: output holds until the next edge, then follows
    apply("R11 setup", 16'h0001, 1'b0);
    @(negedge clk);
    a_in = 16'h0000;
    #2;
    chk("R11 hold before edge", {8'h0, data_ts}, {8'h0, 8'hFD});
    @(posedge clk);
    @(negedge clk);
    chk("R11 update after edge", {8'h0, data_ts}, {8'h0, 8'hFE});

    // R4: term 1 uses both literals of A5
    prog(1'b1, 2'd0, 1, 5, 1'b1);
    prog(1'b1, 2'd1, 1, 5, 1'b1);
    prog(1'b1, 2'd2, 1, 2, 1'b1);
    prog(1'b1, 2'd3, 0, 2, 1'b1);
    apply("R4 both literals A5=1", 16'hFFFF, 1'b0);
    apply("R4 both literals A5=0", 16'h0000, 1'b0);

    // R5: term 2 empty, feeds out3 (non-inverting) and out4 (inverting)
    prog(1'b1, 2'd2, 2, 3, 1'b1);
    prog(1'b1, 2'd2, 2, 4, 1'b1);
    prog(1'b1, 2'd3, 0, 3, 1'b1);
    apply("R5 empty term", 16'h1234, 1'b0);

    // R6: term 3 = A2 also feeds out0
    prog(1'b1, 2'd0, 3, 2, 1'b1);
    prog(1'b1, 2'd2, 3, 0, 1'b1);
    apply("R6 second term", 16'h0004, 1'b0);
    apply("R6 no term", 16'h0002, 1'b0);

    // R9: polarity write without enable is ignored
    prog(1'b0, 2'd3, 0, 5, 1'b1);
    apply("R9 gated write", 16'h0000, 1'b0);
    chk("R9 out5", {15'h0, data_ts[5]}, 16'h0001);

    // R10: term index out of range ignored (would put empty-ish term on out6)
    prog(1'b1, 2'd2, 50, 6, 1'b1);
    prog(1'b1, 2'd0, 52, 0, 1'b1);
    apply("R10 range", 16'h0000, 1'b0);
    apply("R10 range", 16'h0001, 1'b0);

    // R8: deselect
    apply("R8 deselect", 16'h0001, 1'b1);
    apply("R8 reselect", 16'h0001, 1'b0);

    // random configuration of terms 4..47, sparse literals
    for (int m = 4; m < 48; m++) begin
      for (int n = 0; n < 16; n++) begin
        int r = int'($urandom % 32);
        if (r == 0 || r == 2) prog(1'b1, 2'd0, m, n, 1'b1);
        if (r == 1 || r == 2) prog(1'b1, 2'd1, m, n, 1'b1);
      end
      for (int o = 0; o < 8; o++)
        if ($urandom % 6 == 0) prog(1'b1, 2'd2, m, o, 1'b1);
    end
    for (int o = 5; o < 8; o++) prog(1'b1, 2'd3, 0, o, 1'($urandom % 2));

    // R6 R7 R8 random vectors
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic cs;
      a  = 16'($urandom);
      cs = ($urandom % 8 == 0);
      apply("R6 R7 R8 random", a, cs);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule